// File: doc/BRIEF.md
# Complementary Parity Wire-Bundle Self-Test

This block exercises two bundles of wires under test and reports which of them is faulty. A counting-up generator drives the first bundle with its N count bits plus an even-parity bit. A counting-down generator drives the second bundle with its N count bits plus an odd-parity bit. Because the two counters start complemented and move in step, the bundles carry opposite values on every wire at every step (for even N). A short between the bundles, or a switch stuck on between them, therefore disturbs the value on the wire, and the parity check sees it. The parity bit is itself a wire under test, so each bundle has N+1 tested wires.

At the receiving end, each bundle has its own parity checker. A parity error sets that bundle's fail flag, and the flag stays set. One pass visits all 2^N counter values and then raises a done flag. After that, the two fail flags are read out serially through a two-stage shift chain while the shift-mode input is held.

Top module: `wire_pair_bist`

## Requirements
- R1: After reset, `tx_a` is all zeros and `tx_b` is all ones (down count all ones, odd-parity bit 1). `fail_a`, `fail_b` and `done` are 0.
- R2: `tx_a[N-1:0]` is the up count and `tx_a[N]` is the XOR of those bits, so `tx_a` always has even parity.
- R3: `tx_b[N-1:0]` is the down count, which is always the bitwise complement of the up count. `tx_b[N]` makes `tx_b` odd parity.
- R4: Both counts advance by one at each clock edge where `run`=1, `shift_mode`=0 and `done`=0. At every other edge they hold.
- R5: At each advancing edge, `fail_a` becomes 1 if the XOR of all N+1 bits of `rx_a` is 1. Once set, it holds until reset or a shift.
- R6: At each advancing edge, `fail_b` becomes 1 if the XOR of all N+1 bits of `rx_b` is 0. Once set, it holds until reset or a shift.
- R7: The edge that checks the final value (up count all ones) sets `done` instead of advancing. `done` then stays 1, the counts stay frozen, and `rx_a`/`rx_b` are ignored.
- R8: `shift_out` always shows `fail_b`. At each edge with `shift_mode`=1, `fail_b` takes the old `fail_a` and `fail_a` takes 0. Counting and checking pause during these edges.
- R9: A stuck-at fault on any single wire of one bundle is flagged on that bundle only. An AND or OR bridge between equal-position wires of the two bundles is flagged on both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Advance the pattern and check this step |
| shift_mode | input | 1 | Shift the result chain one place |
| rx_a | input | N+1 | Far end of bundle A |
| rx_b | input | N+1 | Far end of bundle B |
| tx_a | output | N+1 | Near end of bundle A (up count, even parity) |
| tx_b | output | N+1 | Near end of bundle B (down count, odd parity) |
| fail_a | output | 1 | Sticky parity failure of bundle A |
| fail_b | output | 1 | Sticky parity failure of bundle B |
| done | output | 1 | All 2^N values checked |
| shift_out | output | 1 | Serial result output |

## Verification
The transmitted words depend on the counter registers only, so each new value appears one edge after the advancing edge. The bench drives and samples just after the falling edge, which makes the value seen in loop step v exactly the v-th pattern. The fail flags and `done` settle at the edge that checks a value. They are therefore sampled after the falling edge that follows the last step, and `shift_out` is sampled after each single shift pulse. The bench computes the expected fail flags by sweeping all 2^N words through the same wire-fault model, once for each injected stuck-at or bridging fault.

// File: rtl/wire_pair_bist.sv
module wire_pair_bist #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         shift_mode,
  input  logic [N:0]   rx_a,
  input  logic [N:0]   rx_b,
  output logic [N:0]   tx_a,
  output logic [N:0]   tx_b,
  output logic         fail_a,
  output logic         fail_b,
  output logic         done,
  output logic         shift_out
);

  logic [N-1:0] up_q, dn_q;
  logic step, last;

  assign step = run && !shift_mode && !done;
  assign last = &up_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '1;
      done <= 1'b0;
    end else if (step) begin
      if (last) begin
        done <= 1'b1;
      end else begin
        up_q <= up_q + 1'b1;
        dn_q <= dn_q - 1'b1;
      end
    end
  end

  assign tx_a = {^up_q, up_q};
  assign tx_b = {~^dn_q, dn_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_a <= 1'b0;
      fail_b <= 1'b0;
    end else if (shift_mode) begin
      fail_b <= fail_a;
      fail_a <= 1'b0;
    end else if (step) begin
      fail_a <= fail_a | (^rx_a);
      fail_b <= fail_b | (~^rx_b);
    end
  end

  assign shift_out = fail_b;

endmodule

// File: rtl/wire_pair_bist_chk.sv
module wire_pair_bist_chk #(
  parameter int N = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       shift_mode,
  input logic [N:0] tx_a,
  input logic [N:0] tx_b,
  input logic       fail_a,
  input logic       fail_b,
  input logic       done
);

  AST_EVEN_A: assert property (@(posedge clk) disable iff (!rst_n) (^tx_a) == 1'b0); // R2
  AST_ODD_B: assert property (@(posedge clk) disable iff (!rst_n) (^tx_b) == 1'b1); // R3
  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n) tx_a[N-1:0] == ~tx_b[N-1:0]); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!run || shift_mode || done) |=> ($stable(tx_a) && $stable(tx_b))); // R4
  AST_FAIL_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (fail_a && !shift_mode) |=> fail_a); // R5
  AST_FAIL_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (fail_b && !shift_mode) |=> fail_b); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R7
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n) shift_mode |=> (fail_b == $past(fail_a) && !fail_a)); // R8

endmodule

bind wire_pair_bist wire_pair_bist_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .shift_mode(shift_mode),
  .tx_a(tx_a), .tx_b(tx_b), .fail_a(fail_a), .fail_b(fail_b), .done(done)
);

// File: tb/test_wire_pair_bist.sv
`timescale 1ns/1ps
module test_wire_pair_bist;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n, run, shift_mode;
  logic [N:0] rx_a, rx_b, tx_a, tx_b;
  logic fail_a, fail_b, done, shift_out;
  logic [N:0] sa_mask_a, sa_val_a, sa_mask_b, sa_val_b, br_mask;
  logic br_or;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wire_pair_bist #(.N(N)) i_wire_pair_bist (
    .clk(clk), .rst_n(rst_n), .run(run), .shift_mode(shift_mode),
    .rx_a(rx_a), .rx_b(rx_b), .tx_a(tx_a), .tx_b(tx_b),
    .fail_a(fail_a), .fail_b(fail_b), .done(done), .shift_out(shift_out)
  );

  function automatic logic [2*N+1:0] wires(input logic [N:0] a, input logic [N:0] b);
    logic [N:0] ab, ra, rb;
    ab = br_or ? (a | b) : (a & b);
    ra = (a & ~br_mask) | (ab & br_mask);
    rb = (b & ~br_mask) | (ab & br_mask);
    ra = (ra & ~sa_mask_a) | (sa_val_a & sa_mask_a);
    rb = (rb & ~sa_mask_b) | (sa_val_b & sa_mask_b);
    return {ra, rb};
  endfunction

  always_comb {rx_a, rx_b} = wires(tx_a, tx_b);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_faults();
    sa_mask_a = '0; sa_val_a = '0; sa_mask_b = '0; sa_val_b = '0;
    br_mask = '0; br_or = 1'b0;
  endtask

  task automatic sweep(input bit extras);
    logic ea, eb;
    logic [2*N+1:0] w;
    logic [N-1:0] u;
    ea = 1'b0; eb = 1'b0;
    for (int v = 0; v < (1 << N); v++) begin
      u = v[N-1:0];
      w = wires({^u, u}, {~^(~u), ~u});
      ea = ea | (^w[2*N+1:N+1]);
      eb = eb | (~^w[N:0]);
    end
    rst_n = 1'b0; run = 1'b0; shift_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 tx_a reset", tx_a, '0);
    chk("R1 tx_b reset", tx_b, {(N+1){1'b1}});
    chk("R1 flags reset", {fail_a, fail_b, done}, 3'b000);
    run = 1'b1;
    for (int v = 0; v < (1 << N); v++) begin
      u = v[N-1:0];
      chk("R2 tx_a word", tx_a, {^u, u});
      chk("R3 tx_b word", tx_b, {~^(~u), ~u});
      chk("R7 done early", done, 1'b0);
      if (extras && v == 5) begin
        run = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R4 hold when idle", tx_a, {^u, u});
        run = 1'b1; shift_mode = 1'b1;
        @(negedge clk);
        shift_mode = 1'b0;
        #1;
        chk("R8 hold during shift", tx_b, {~^(~u), ~u});
      end
      @(negedge clk);
      #1;
    end
    chk("R7 done set", done, 1'b1);
    chk("R5 R9 fail_a", fail_a, ea);
    chk("R6 R9 fail_b", fail_b, eb);
    @(negedge clk);
    #1;
    chk("R7 frozen at last", tx_a, {1'b0, {N{1'b1}}});
    if (extras) begin
      sa_mask_a = 'b1; sa_val_a = '0;
      sa_mask_b = 'b1; sa_val_b = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R7 ignored after done", {fail_a, fail_b, done}, 3'b001);
      clear_faults();
    end
    run = 1'b0;
    chk("R8 first out", shift_out, eb);
    shift_mode = 1'b1;
    @(negedge clk);
    shift_mode = 1'b0;
    #1;
    chk("R8 second out", shift_out, ea);
    shift_mode = 1'b1;
    @(negedge clk);
    shift_mode = 1'b0;
    #1;
    chk("R8 drained", {shift_out, fail_a}, 2'b00);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_faults();
    rst_n = 1'b0; run = 1'b0; shift_mode = 1'b0;
    sweep(1'b1);
    for (int k = 0; k <= N; k++) begin
      for (int p = 0; p < 2; p++) begin
        clear_faults();
        sa_mask_a = (N+1)'(1) << k; sa_val_a = p[0] ? sa_mask_a : '0;
        sweep(1'b0);
        clear_faults();
        sa_mask_b = (N+1)'(1) << k; sa_val_b = p[0] ? sa_mask_b : '0;
        sweep(1'b0);
        clear_faults();
        br_mask = (N+1)'(1) << k; br_or = p[0];
        sweep(1'b0);
      end
    end
    clear_faults();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule